// File: doc/BRIEF.md
# Software-Generated Interrupt Acceptance Filter

This block decides whether a software-generated interrupt request may set the pending bit of one of the local interrupts. Each request carries a target number, a requested group (group 0, secure group 1 or non-secure group 1) and a flag that marks it as coming from a non-secure originator. The filter compares the request with the target's configured group. That group is resolved from a group bit and a modifier bit. When security is enabled, the filter also checks the target's 2-bit non-secure permission level.

The filter takes at most one request per cycle, qualified by a valid strobe. It registers its decision, so the decision appears one cycle after the request. An accepted request produces a set-pending pulse that carries the target number and a one-hot mask. The consumer uses that pulse to set the pending bit and to re-run its highest-priority selection. A target number at or above the interrupt count is dropped and flagged.

Top module: `sgi_accept_filter`

## Requirements
- R1: While reset is low, at the next clock edge `dec_vld`, `dec_accept`, `dec_range_err`, `set_pend_vld` and `set_pend_mask` all become 0.
- R2: A request taken with `req_vld`=1 at one rising edge produces `dec_vld`=1 after that edge, lasting one cycle. A cycle without `req_vld` produces `dec_vld`=0.
- R3: With `sec_dis`=0, the configured group of interrupt i comes from {`cfg_mod_bit[i]`,`cfg_grp_bit[i]`}: 00 gives group 0, 10 gives secure group 1, and 01 or 11 give non-secure group 1.
- R4: With `sec_dis`=1, the modifier bit and the permission field are ignored. `cfg_grp_bit[i]`=0 gives group 0 and 1 gives non-secure group 1.
- R5: A secure group 1 request aimed at a group 0 interrupt is handled as a group 0 request.
- R6: A group 0 request, including one remapped by R5, is dropped when the target is not group 0.
- R7: With `sec_dis`=0 and `req_ns`=1, a request aimed at a group 0 interrupt is accepted only when the target's permission field `cfg_acl[2i+1:2i]` is 1 or more.
- R8: With `sec_dis`=0 and `req_ns`=1, a request aimed at a secure group 1 interrupt is accepted only when the permission field is 2 or more.
- R9: Every other request with a valid group code and an in-range target is accepted. This covers any request aimed at a non-secure group 1 interrupt, secure-origin requests that pass R6, and a non-secure group 1 request aimed at a group 0 interrupt.
- R10: A target number of `NUM_IRQ` or more is dropped, with `dec_range_err`=1 and no set-pending pulse.
- R11: An accepted decision raises `set_pend_vld` with `set_pend_id` equal to the target and `set_pend_mask` holding only that target's bit. A dropped decision leaves `set_pend_vld`=0 and the mask at all zeros.
- R12: The request group is coded as 0 for group 0, 1 for secure group 1 and 2 for non-secure group 1. Code 3 is reserved and is always dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_id | input | ID_W | Target interrupt number |
| req_grp | input | 2 | Requested group code (R12) |
| req_ns | input | 1 | Request comes from a non-secure originator |
| sec_dis | input | 1 | Security disabled |
| cfg_grp_bit | input | NUM_IRQ | Group bit per interrupt |
| cfg_mod_bit | input | NUM_IRQ | Group modifier bit per interrupt |
| cfg_acl | input | 2*NUM_IRQ | Non-secure permission level, 2 bits per interrupt |
| dec_vld | output | 1 | Decision valid |
| dec_accept | output | 1 | Decision: accepted |
| dec_range_err | output | 1 | Decision: target out of range |
| set_pend_vld | output | 1 | Set-pending pulse |
| set_pend_id | output | IDX_W | Target of the set-pending pulse |
| set_pend_mask | output | NUM_IRQ | One-hot set-pending mask |

## Verification
A wrong resolved group or a misread permission field shows up as a flipped `dec_accept` on the cycle after the offending request, with nothing carried into later cycles. A mis-indexed configuration lookup accepts or drops according to a neighbouring interrupt's settings, so the sweep fills every other interrupt with the opposite settings. A wrong mask decode shows up in `set_pend_mask` in that same decision cycle.

// File: rtl/sgi_filt_pkg.sv
// Shared types for the software-generated interrupt acceptance filter.
// Assumes group codes fit in two bits; code 3 is reserved.
package sgi_filt_pkg;
    typedef enum logic [1:0] {
        GRP_S0  = 2'd0,
        GRP_S1  = 2'd1,
        GRP_NS1 = 2'd2,
        GRP_RSV = 2'd3
    } grp_e;

    localparam int unsigned ACL_W = 2;
endpackage

// File: rtl/sgi_group_resolve.sv
// Resolves the effective group of every interrupt from its group bit,
// its modifier bit and the security-disable input.
// Assumes the configuration inputs are static while requests are served.
module sgi_group_resolve
    import sgi_filt_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 16
) (
    input  logic                   sec_dis,
    input  logic [NUM_IRQ-1:0]     grp_bit,
    input  logic [NUM_IRQ-1:0]     mod_bit,
    output logic [2*NUM_IRQ-1:0]   eff_grp
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_res
        grp_e one_grp;
        // Map the bit pair of interrupt i to its group.
        always_comb begin
            if (grp_bit[i])
                one_grp = GRP_NS1;
            else if (mod_bit[i] && !sec_dis)
                one_grp = GRP_S1;
            else
                one_grp = GRP_S0;
        end
        assign eff_grp[2*i +: 2] = one_grp;
    end
endmodule

// File: rtl/sgi_rule_check.sv
// Applies the group remap, the group match and the non-secure permission
// rules to one request against one resolved target group.
// Assumes the target has already been range-checked by the caller.
module sgi_rule_check
    import sgi_filt_pkg::*;
(
    input  grp_e              req_grp,
    input  grp_e              tgt_grp,
    input  logic              req_ns,
    input  logic              sec_dis,
    input  logic [ACL_W-1:0]  acl,
    output logic              accept
);
    grp_e eff_req;

    // Treat a secure group 1 request on a group 0 target as group 0.
    always_comb begin
        if (tgt_grp == GRP_S0 && req_grp == GRP_S1)
            eff_req = GRP_S0;
        else
            eff_req = req_grp;
    end

    // Decide acceptance from the group match and permission level.
    always_comb begin
        accept = 1'b1;
        if (eff_req == GRP_RSV)
            accept = 1'b0;
        else if (eff_req == GRP_S0 && tgt_grp != GRP_S0)
            accept = 1'b0;
        else if (req_ns && !sec_dis) begin
            if (tgt_grp == GRP_S0 && acl < 2'd1)
                accept = 1'b0;
            else if (tgt_grp == GRP_S1 && acl < 2'd2)
                accept = 1'b0;
        end
    end

    // Guard the permission and group rules on the raw inputs.
    always_comb begin
        // R7
        if (req_ns === 1'b1 && sec_dis === 1'b0 && tgt_grp == GRP_S0 && acl == 2'd0)
            ns_g0_acl_chk: assert (!accept);
        // R8
        if (req_ns === 1'b1 && sec_dis === 1'b0 && tgt_grp == GRP_S1 && acl != 2'd3 && acl != 2'd2)
            ns_g1s_acl_chk: assert (!accept);
        // R6
        if (req_grp == GRP_S0 && tgt_grp != GRP_S0)
            g0_mismatch_chk: assert (!accept);
        // R12
        if (req_grp == GRP_RSV)
            rsv_code_chk: assert (!accept);
    end
endmodule

// File: rtl/sgi_accept_filter.sv
// Top of the acceptance filter: looks up the target's configuration,
// runs the rule check and registers the decision and set-pending pulse.
// Assumes one request per cycle and configuration stable around it.
module sgi_accept_filter
    import sgi_filt_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 16,
    parameter int unsigned ID_W    = 5,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_vld,
    input  logic [ID_W-1:0]          req_id,
    input  logic [1:0]               req_grp,
    input  logic                     req_ns,
    input  logic                     sec_dis,
    input  logic [NUM_IRQ-1:0]       cfg_grp_bit,
    input  logic [NUM_IRQ-1:0]       cfg_mod_bit,
    input  logic [2*NUM_IRQ-1:0]     cfg_acl,
    output logic                     dec_vld,
    output logic                     dec_accept,
    output logic                     dec_range_err,
    output logic                     set_pend_vld,
    output logic [IDX_W-1:0]         set_pend_id,
    output logic [NUM_IRQ-1:0]       set_pend_mask
);
    logic [2*NUM_IRQ-1:0] eff_grp;
    logic                 in_range;
    logic [IDX_W-1:0]     idx;
    grp_e                 tgt_grp;
    logic [ACL_W-1:0]     tgt_acl;
    logic                 rule_ok;
    logic                 acc_c;
    logic [NUM_IRQ-1:0]   mask_c;

    sgi_group_resolve #(.NUM_IRQ(NUM_IRQ)) res_i (
        .sec_dis (sec_dis),
        .grp_bit (cfg_grp_bit),
        .mod_bit (cfg_mod_bit),
        .eff_grp (eff_grp)
    );

    // Range-check the target and select its configuration.
    always_comb begin
        in_range = (req_id < ID_W'(NUM_IRQ));
        idx      = req_id[IDX_W-1:0];
        tgt_grp  = grp_e'(eff_grp[{idx, 1'b0} +: 2]);
        tgt_acl  = cfg_acl[{idx, 1'b0} +: 2];
    end

    sgi_rule_check rule_i (
        .req_grp (grp_e'(req_grp)),
        .tgt_grp (tgt_grp),
        .req_ns  (req_ns),
        .sec_dis (sec_dis),
        .acl     (tgt_acl),
        .accept  (rule_ok)
    );

    assign acc_c = req_vld && in_range && rule_ok;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
        assign mask_c[i] = acc_c && (idx == IDX_W'(i));
    end

    // Register the decision and the set-pending pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld       <= 1'b0;
            dec_accept    <= 1'b0;
            dec_range_err <= 1'b0;
            set_pend_vld  <= 1'b0;
            set_pend_id   <= '0;
            set_pend_mask <= '0;
        end else begin
            dec_vld       <= req_vld;
            dec_accept    <= acc_c;
            dec_range_err <= req_vld && !in_range;
            set_pend_vld  <= acc_c;
            set_pend_id   <= acc_c ? idx : '0;
            set_pend_mask <= mask_c;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!dec_vld && !set_pend_vld && set_pend_mask == '0));
    // R2
    dec_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> dec_vld);
    // R2
    no_idle_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !dec_vld);
    // R10
    range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_id >= ID_W'(NUM_IRQ)) |=> (dec_range_err && !set_pend_vld));
    // R11
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend_vld |-> (set_pend_mask == (NUM_IRQ'(1) << set_pend_id)));
    // R11
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_pend_vld |-> (set_pend_mask == '0));
endmodule

// File: tb/sgi_accept_filter_tb_top.sv
module sgi_accept_filter_tb_top;
    localparam int NUM = 16;
    localparam int IW  = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_vld = 1'b0;
    logic [IW-1:0]   req_id = '0;
    logic [1:0]      req_grp = '0;
    logic            req_ns = 1'b0;
    logic            sec_dis = 1'b0;
    logic [NUM-1:0]  cfg_grp_bit = '0;
    logic [NUM-1:0]  cfg_mod_bit = '0;
    logic [2*NUM-1:0] cfg_acl = '0;
    logic            dec_vld, dec_accept, dec_range_err, set_pend_vld;
    logic [3:0]      set_pend_id;
    logic [NUM-1:0]  set_pend_mask;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sgi_accept_filter #(.NUM_IRQ(NUM), .ID_W(IW)) dut_i (
        .clk, .rst_n, .req_vld, .req_id, .req_grp, .req_ns, .sec_dis,
        .cfg_grp_bit, .cfg_mod_bit, .cfg_acl,
        .dec_vld, .dec_accept, .dec_range_err, .set_pend_vld,
        .set_pend_id, .set_pend_mask
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {dec_vld, dec_accept, dec_range_err, set_pend_vld, set_pend_mask},
              64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle cycle gives no decision
        check("R2 idle", {63'd0, dec_vld}, 64'd0);

        for (int id = 0; id < 18; id++)
        for (int sd = 0; sd < 2; sd++)
        for (int g = 0; g < 2; g++)
        for (int m = 0; m < 2; m++)
        for (int a = 0; a < 4; a++)
        for (int rg = 0; rg < 4; rg++)
        for (int ns = 0; ns < 2; ns++) begin
            int    cfg;
            int    rq;
            bit    acc;
            bit    rng;
            string tag;
            logic [NUM-1:0] emask;
            // neighbours get the opposite settings
            cfg_grp_bit = {NUM{~g[0]}};
            cfg_mod_bit = {NUM{~m[0]}};
            for (int k = 0; k < NUM; k++) cfg_acl[2*k +: 2] = ~a[1:0];
            if (id < NUM) begin
                cfg_grp_bit[id] = g[0];
                cfg_mod_bit[id] = m[0];
                cfg_acl[2*id +: 2] = a[1:0];
            end
            sec_dis = sd[0];
            req_id  = IW'(id);
            req_grp = rg[1:0];
            req_ns  = ns[0];
            req_vld = 1'b1;
            // expected result from the requirements
            // group codes: 0 = group 0, 1 = secure group 1, 2 = non-secure group 1
            if (g == 1) cfg = 2;
            else if (m == 1 && sd == 0) cfg = 1;
            else cfg = 0;
            rq = rg;
            rng = (id >= NUM);
            acc = 1'b1;
            tag = (sd == 1) ? "R4" : "R3 R9";
            if (rng) begin acc = 0; tag = "R10"; end
            else if (rq == 3) begin acc = 0; tag = "R12"; end
            else begin
                if (cfg == 0 && rq == 1) begin rq = 0; tag = "R5"; end
                if (rq == 0 && cfg != 0) begin acc = 0; tag = "R6"; end
                else if (ns == 1 && sd == 0 && cfg == 0) begin acc = (a >= 1); tag = "R7"; end
                else if (ns == 1 && sd == 0 && cfg == 1) begin acc = (a >= 2); tag = "R8"; end
            end
            emask = acc ? (NUM'(1) << id) : '0;
            @(negedge clk);
            req_vld = 1'b0;
            check(tag, {59'd0, dec_vld, dec_accept, dec_range_err, set_pend_vld}, {59'd0, 1'b1, acc, rng, acc});
            check("R11 mask/id", {44'd0, set_pend_mask, set_pend_id},
                  {44'd0, emask, acc ? 4'(id) : 4'd0});
        end

        @(negedge clk);
        check("R2 no decision after gap", {63'd0, dec_vld}, 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule